// File: doc/BRIEF.md
# I2C Receive Byte FIFO with Threshold Event

This block sits between the byte shift engine of an I2C controller and the host register port. The shift engine pushes each received byte into a 32-entry queue. The host pops bytes from the head, and the head byte shows on the read-data port without a wait cycle. The block reports its occupancy as a 6-bit count together with live full and empty flags.

A programmable threshold sets a sticky event bit. It sets only when the byte count climbs up to the threshold from below. An optional "last group" control tells the shift engine which incoming byte must be answered with NACK, so that the receive ends on the byte that completes the group. A clear input empties the queue in one cycle. There are sticky status bits for "became full" and "overflow". Each sticky bit is cleared by a one-cycle write-1 pulse.

Top module: `rx_byte_queue`

## Requirements
- R1: After reset, count_o is 0, empty_o is 1, full_o is 0, all sticky status outputs are 0, rd_data_o is 8'hFF and nack_o is 0 (provided last_en_i is 0).
- R2: Bytes leave in the order they were pushed. rd_data_o always shows the current head byte, and an accepted pop moves to the next byte at the next clock edge.
- R3: A pop while the queue is empty has no effect: rd_data_o reads 8'hFF, the count stays 0 and no status bit changes.
- R4: A push while the count is 32 and no pop is requested is dropped. The count stays 32, the queued data is unchanged, and ovf_o sets and stays set until an ovf_clr_i pulse.
- R5: A push and a pop in the same cycle on a non-empty queue leave the count unchanged, including when the queue is full. On an empty queue only the push takes effect.
- R6: thr_hit_o sets at the clock edge where the count changes from below thr_i to exactly thr_i. Reaching thr_i from above, or staying at thr_i, does not set it. The valid range of thr_i is 1 to 32.
- R7: thr_hit_o is sticky and is cleared by a one-cycle thr_clr_i pulse. If a new crossing happens in the same cycle as the clear, the bit stays set.
- R8: nack_o is 1 exactly when last_en_i is 1 and count_o equals thr_i minus 1, so that the byte which brings the count to the threshold is answered with NACK.
- R9: full_evt_o sets at the clock edge where the count becomes 32. It is sticky, and a full_clr_i pulse clears it; a new set event in the same cycle wins over the clear.
- R10: clear_i empties the queue at the next edge (count 0, empty_o 1, rd_data_o 8'hFF). It takes priority over a push or a pop in the same cycle and leaves the sticky bits unchanged.
- R11: count_o is a 6-bit occupancy from 0 to 32. full_o is 1 exactly when the count is 32, and empty_o is 1 exactly when the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Shift engine delivers a byte |
| push_data_i | input | 8 | Received byte |
| pop_i | input | 1 | Host takes the head byte |
| rd_data_o | output | 8 | Head byte, 8'hFF when empty |
| thr_i | input | 6 | Threshold, 1 to 32 |
| last_en_i | input | 1 | NACK the byte that completes the group |
| clear_i | input | 1 | Empty the queue |
| thr_clr_i | input | 1 | Write-1 clear of thr_hit_o |
| full_clr_i | input | 1 | Write-1 clear of full_evt_o |
| ovf_clr_i | input | 1 | Write-1 clear of ovf_o |
| count_o | output | 6 | Occupancy |
| empty_o | output | 1 | Count is 0 |
| full_o | output | 1 | Count is 32 |
| thr_hit_o | output | 1 | Sticky threshold crossing status |
| full_evt_o | output | 1 | Sticky became-full status |
| ovf_o | output | 1 | Sticky dropped-push status |
| nack_o | output | 1 | Next byte must be answered with NACK |

## Verification
The assertions assume that thr_i stays within 1 to 32. They also assume that thr_i and last_en_i do not change between the cycle a push is sampled and the next edge. Without these conditions the crossing and NACK properties are not defined. The stimulus draws thr_i with $urandom_range(1, 32) and changes it only at the start of a step, so every value it drives is legal. Push and pop densities change from phase to phase, so that full, empty, simultaneous push and pop, and overflow all occur.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef struct packed {
    logic thr_hit;
    logic full_evt;
    logic ovf;
  } rxq_stat_t;

  typedef struct packed {
    logic thr;
    logic full;
    logic ovf;
  } rxq_clr_t;
endpackage

// File: rtl/rxq_mem.sv
module rxq_mem #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_ptr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_ptr_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] cell_w [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic [DW-1:0] cell_q;
    always_ff @(posedge clk_i) begin
      if (wr_en_i && (wr_ptr_i == AW'(i))) cell_q <= wr_data_i;
    end
    assign cell_w[i] = cell_q;
  end

  assign rd_data_o = cell_w[rd_ptr_i];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          clear_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic [AW-1:0] rd_ptr_o,
  output logic [CW-1:0] cnt_q_o,
  output logic [CW-1:0] cnt_d_o
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop, is_full, is_empty;

  assign is_full  = (cnt_q == FULL_CNT);
  assign is_empty = (cnt_q == '0);
  assign do_pop   = pop_i && !is_empty && !clear_i;
  // a pop frees the slot the same-cycle push needs
  assign do_push  = push_i && (!is_full || do_pop) && !clear_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)                cnt_d = '0;
    else if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (clear_i) begin
        wr_ptr_q <= '0;
        rd_ptr_q <= '0;
      end else begin
        if (do_push) wr_ptr_q <= (wr_ptr_q == LAST_IDX) ? '0 : wr_ptr_q + 1'b1;
        if (do_pop)  rd_ptr_q <= (rd_ptr_q == LAST_IDX) ? '0 : rd_ptr_q + 1'b1;
      end
    end
  end

  assign wr_en_o  = do_push;
  assign wr_ptr_o = wr_ptr_q;
  assign rd_ptr_o = rd_ptr_q;
  assign cnt_q_o  = cnt_q;
  assign cnt_d_o  = cnt_d;

  assert_clear_empties_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0) && (rd_ptr_q == wr_ptr_q));
  assert_empty_pop_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !clear_i && is_empty) |=> (cnt_q == '0) && $stable(rd_ptr_q));
  assert_full_push_dropped_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !clear_i && is_full) |=> (cnt_q == FULL_CNT) && $stable(wr_ptr_q));
  assert_push_pop_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !clear_i && !is_empty) |=> $stable(cnt_q));
  assert_count_range_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_CNT);
endmodule

// File: rtl/rxq_stat.sv
module rxq_stat
  import rxq_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_q_i,
  input  logic [CW-1:0] cnt_d_i,
  input  logic [CW-1:0] thr_i,
  input  logic          last_en_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          clear_i,
  input  rxq_clr_t      clr_i,
  output rxq_stat_t     stat_o,
  output logic          nack_o
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  rxq_stat_t stat_q, set_w;
  logic      full_now;

  assign full_now         = (cnt_q_i == FULL_CNT);
  // crossing from below only
  assign set_w.thr_hit    = (cnt_q_i < thr_i) && (cnt_d_i == thr_i);
  assign set_w.full_evt   = !full_now && (cnt_d_i == FULL_CNT);
  assign set_w.ovf        = push_i && !pop_i && !clear_i && full_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
    end else begin
      stat_q.thr_hit  <= set_w.thr_hit  || (stat_q.thr_hit  && !clr_i.thr);
      stat_q.full_evt <= set_w.full_evt || (stat_q.full_evt && !clr_i.full);
      stat_q.ovf      <= set_w.ovf      || (stat_q.ovf      && !clr_i.ovf);
    end
  end

  assign stat_o = stat_q;
  assign nack_o = last_en_i && ((cnt_q_i + 1'b1) == thr_i);

  assert_thr_from_below_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_q.thr_hit) |-> ($past(cnt_q_i) < $past(thr_i)) && (cnt_q_i == $past(thr_i)));
  assert_thr_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q.thr_hit && !clr_i.thr) |=> stat_q.thr_hit);
  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !clear_i && full_now) |=> stat_q.ovf);
  assert_full_evt_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_q.full_evt) |-> (cnt_q_i == FULL_CNT) && ($past(cnt_q_i) != FULL_CNT));
endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] rd_data_o,
  input  logic [CW-1:0] thr_i,
  input  logic          last_en_i,
  input  logic          clear_i,
  input  logic          thr_clr_i,
  input  logic          full_clr_i,
  input  logic          ovf_clr_i,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          thr_hit_o,
  output logic          full_evt_o,
  output logic          ovf_o,
  output logic          nack_o
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic          wr_en;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] head;
  rxq_stat_t     stat;
  rxq_clr_t      clr;

  assign clr = '{thr: thr_clr_i, full: full_clr_i, ovf: ovf_clr_i};

  rxq_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk_i, .rst_ni, .push_i, .pop_i, .clear_i,
    .wr_en_o(wr_en), .wr_ptr_o(wr_ptr), .rd_ptr_o(rd_ptr),
    .cnt_q_o(cnt_q), .cnt_d_o(cnt_d)
  );

  rxq_mem #(.DEPTH(DEPTH), .DW(DW)) i_mem (
    .clk_i, .wr_en_i(wr_en), .wr_ptr_i(wr_ptr), .wr_data_i(push_data_i),
    .rd_ptr_i(rd_ptr), .rd_data_o(head)
  );

  rxq_stat #(.DEPTH(DEPTH)) i_stat (
    .clk_i, .rst_ni, .cnt_q_i(cnt_q), .cnt_d_i(cnt_d), .thr_i, .last_en_i,
    .push_i, .pop_i, .clear_i, .clr_i(clr), .stat_o(stat), .nack_o
  );

  assign count_o    = cnt_q;
  assign empty_o    = (cnt_q == '0);
  assign full_o     = (cnt_q == FULL_CNT);
  assign rd_data_o  = empty_o ? '1 : head;
  assign thr_hit_o  = stat.thr_hit;
  assign full_evt_o = stat.full_evt;
  assign ovf_o      = stat.ovf;

  assert_nack_completes_group_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nack_o && push_i && !pop_i && !clear_i) |=> (count_o == $past(thr_i)));
  assert_empty_reads_ff_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (rd_data_o == '1));
endmodule

// File: tb/test_rx_byte_queue.sv
module test_rx_byte_queue;
  localparam int CLK_PERIOD = 10;
  localparam int D = 32;

  logic       clk = 0, rst_n = 0;
  logic       push = 0, pop = 0, clear = 0, thr_clr = 0, full_clr = 0, ovf_clr = 0, last_en = 0;
  logic [7:0] pdata = 0;
  logic [5:0] thr = 6'd4;
  logic [7:0] rd_data;
  logic [5:0] count;
  logic       empty, full, thr_hit, full_evt, ovf, nack;

  int total = 0, bad = 0;
  logic [7:0] mq[$];
  logic m_hit = 0, m_fev = 0, m_ovf = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_byte_queue i_rx_byte_queue (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push), .push_data_i(pdata), .pop_i(pop),
    .rd_data_o(rd_data), .thr_i(thr), .last_en_i(last_en), .clear_i(clear),
    .thr_clr_i(thr_clr), .full_clr_i(full_clr), .ovf_clr_i(ovf_clr),
    .count_o(count), .empty_o(empty), .full_o(full), .thr_hit_o(thr_hit),
    .full_evt_o(full_evt), .ovf_o(ovf), .nack_o(nack)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_head();
    return (mq.size() != 0) ? int'(mq[0]) : 8'hFF;
  endfunction

  function automatic bit exp_nack();
    return last_en && (mq.size() + 1 == int'(thr));
  endfunction

  task automatic check_regs();
    chk("R11 count", count, mq.size());
    chk("R11 empty", empty, mq.size() == 0);
    chk("R11 full", full, mq.size() == D);
    chk("R6 thr_hit", thr_hit, m_hit);
    chk("R9 full_evt", full_evt, m_fev);
    chk("R4 ovf", ovf, m_ovf);
  endtask

  // drive at negedge, check combinational outputs, advance model and clock
  task automatic step(input bit ps, input logic [7:0] d, input bit pp, input bit cl,
                      input bit tc, input bit fc, input bit oc);
    int c0, c1;
    bit pop_eff, push_eff;
    push = ps; pdata = d; pop = pp; clear = cl; thr_clr = tc; full_clr = fc; ovf_clr = oc;
    #1;
    chk("R2 head", rd_data, exp_head());
    chk("R8 nack", nack, exp_nack());
    c0 = mq.size();
    pop_eff  = pp && c0 > 0 && !cl;
    push_eff = ps && (c0 < D || pop_eff) && !cl;
    if (cl) mq.delete();
    else begin
      if (pop_eff) void'(mq.pop_front());
      if (push_eff) mq.push_back(d);
    end
    c1 = mq.size();
    m_hit = ((c0 < int'(thr)) && (c1 == int'(thr))) || (m_hit && !tc);
    m_fev = ((c0 != D) && (c1 == D)) || (m_fev && !fc);
    m_ovf = (ps && !pp && !cl && c0 == D) || (m_ovf && !oc);
    @(posedge clk);
    @(negedge clk);
    push = 0; pop = 0; clear = 0; thr_clr = 0; full_clr = 0; ovf_clr = 0;
    check_regs();
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1c2a));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 sticky", {thr_hit, full_evt, ovf}, 0);
    chk("R1 rd_data", rd_data, 8'hFF);
    chk("R1 nack", nack, 0);

    // R3 pop on empty
    step(0, 0, 1, 0, 0, 0, 0);
    chk("R3 count", count, 0);
    chk("R3 rd_data", rd_data, 8'hFF);
    chk("R3 flags", {thr_hit, full_evt, ovf}, 0);

    // R5 push+pop on empty: only push lands
    step(1, 8'h3C, 1, 0, 0, 0, 0);
    chk("R5 empty push+pop", count, 1);
    chk("R2 first byte", rd_data, 8'h3C);
    step(0, 0, 1, 0, 0, 0, 0);

    // R8 / R6: last group of 3 bytes
    thr = 6'd3; last_en = 1;
    step(1, 8'h11, 0, 0, 0, 0, 0);
    step(1, 8'h22, 0, 0, 0, 0, 0);
    #1 chk("R8 nack on group end", nack, 1);
    step(1, 8'h33, 0, 0, 0, 0, 0);
    chk("R6 crossing", thr_hit, 1);
    #1 chk("R8 nack after group", nack, 0);
    last_en = 0;

    // R6 reaching from above does not set
    step(0, 0, 0, 0, 1, 0, 0);
    step(1, 8'h44, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0);
    chk("R6 from above", thr_hit, 0);

    // R7 clear and new crossing in same cycle
    step(0, 0, 1, 0, 0, 0, 0);
    step(1, 8'h55, 0, 0, 1, 0, 0);
    chk("R7 set wins", thr_hit, 1);
    step(0, 0, 0, 0, 1, 0, 0);
    chk("R7 cleared", thr_hit, 0);

    // R10 clear beats push
    step(1, 8'h66, 0, 1, 0, 0, 0);
    chk("R10 count", count, 0);
    chk("R10 rd_data", rd_data, 8'hFF);

    // R4 / R9 / R5 at full
    for (int i = 0; i < D; i++) step(1, 8'(i * 7 + 1), 0, 0, 0, 0, 0);
    chk("R9 full_evt", full_evt, 1);
    step(1, 8'hEE, 0, 0, 0, 0, 0);
    chk("R4 dropped", count, D);
    chk("R4 ovf", ovf, 1);
    chk("R4 head kept", rd_data, 8'h01);
    step(1, 8'hAB, 1, 0, 0, 0, 0);
    chk("R5 full push+pop", count, D);
    step(0, 0, 0, 0, 0, 1, 1);
    chk("R9 cleared", full_evt, 0);
    chk("R4 cleared", ovf, 0);
    for (int i = 0; i < D; i++) step(0, 0, 1, 0, 0, 0, 0);
    chk("R2 drained", count, 0);

    // constrained random phases
    for (int ph = 0; ph < 12; ph++) begin
      int pp_w = (ph % 3 == 0) ? 80 : (ph % 3 == 1) ? 30 : 55;
      int po_w = (ph % 3 == 0) ? 25 : (ph % 3 == 1) ? 75 : 50;
      for (int s = 0; s < 400; s++) begin
        if (s % 50 == 0) begin
          thr = 6'($urandom_range(1, D));
          last_en = $urandom_range(0, 1);
        end
        step($urandom_range(0, 99) < pp_w, 8'($urandom), $urandom_range(0, 99) < po_w,
             $urandom_range(0, 199) == 0, $urandom_range(0, 19) == 0,
             $urandom_range(0, 19) == 0, $urandom_range(0, 19) == 0);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule